// File: doc/BRIEF.md
# Complementary PWM Generator with Minimum-Duty Clamp

This block is a free-running pulse-width modulator that drives a complementary high-side/low-side output pair. A period counter runs from zero up to one less than the programmed period, then wraps. The high output is asserted while the counter is below the effective duty value, and the low output is always its complement. Configuration arrives on a single-cycle write-strobe port with a two-bit address.

The duty value can come from one of two registers: a shared master duty register or this channel's own duty register. A source-select bit picks between them. Any duty value below the minimum of 0x0010 is forced to zero before use, so very small duty values give a steadily low high-side output and never the inverted state.

A configuration bit chooses between two update modes. In immediate mode, a written duty value drives the outputs from the cycle after the write. In buffered mode, the value waits and is copied into the active duty register when the counter wraps to zero. Register map: address 0 is the period, address 1 the master duty, address 2 the channel duty, and address 3 the configuration. In the configuration word, bit 0 enables immediate update, and bit 1 selects the master source when set or the channel source when clear.

Top module: `pwm_duty_gen`

## Requirements
- R1: After reset both duty registers are zero, so pwmHigh is 0 and pwmLow is 1; the period register resets to 64 and the configuration to buffered mode with the channel source.
- R2: pwmLow is the inverse of pwmHigh on every cycle.
- R3: With period P and a duty value d where 0x0010 <= d < P, pwmHigh is high for exactly d of every P consecutive cycles, and the counter wraps to 0 after reaching P-1.
- R4: A selected duty value below 0x0010 gives the same outputs as a duty of zero (pwmHigh held at 0, never inverted), in both update modes.
- R5: A duty value of exactly 0x0010 is honoured and gives 16 high cycles per period.
- R6: A duty value at or above the period holds pwmHigh continuously at 1.
- R7: In buffered mode (configuration bit 0 clear), a duty write does not change the current period's pulse; the new value applies from the next counter wrap.
- R8: In immediate mode (configuration bit 0 set), a duty write sets the pulse width from the cycle after the write, within the current period.
- R9: Configuration bit 1 selects the master duty (address 1) when set and the channel duty (address 2) when clear; a write to the register that is not selected has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address (0 period, 1 master duty, 2 channel duty, 3 config) |
| wrData | input | 16 | Write data |
| pwmHigh | output | 1 | High-side PWM output |
| pwmLow | output | 1 | Low-side PWM output, complement of pwmHigh |

## Verification
The embedded assertions check on every cycle that the counter wraps once it reaches the end of the period, that the active duty register stays unchanged between wraps unless a load is requested, that a sub-minimum duty never raises the high output in immediate mode, that a duty at or above the period keeps it high, and that writing the unselected duty source leaves the selected value alone. Only the directed scenarios can show pulse widths over whole periods, where within a period a buffered or immediate write takes effect, and the exact behaviour at the 0x000F/0x0010 boundary.

// File: rtl/pwm_duty_pkg.sv
package pwm_duty_pkg;

  typedef enum logic [1:0] {
    ADDR_PERIOD = 2'd0,
    ADDR_MASTER = 2'd1,
    ADDR_CHAN   = 2'd2,
    ADDR_CFG    = 2'd3
  } regAddr_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadDuty;   // copy selected duty into the active register
    logic useDirect;  // compare against selected duty directly
  } dutyStrobe_t;

endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_duty_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int RST_PERIOD = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             atWrap,
  output logic [CNT_W-1:0] periodVal,
  output logic [CNT_W-1:0] rawDuty,
  output logic             immMode,
  output dutyStrobe_t      strb
);

  logic [CNT_W-1:0] masterDuty;
  logic [CNT_W-1:0] chanDuty;
  logic             useMaster;
  regAddr_e         addrDec;

  assign addrDec = regAddr_e'(wrAddr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodVal  <= CNT_W'(RST_PERIOD);
      masterDuty <= '0;
      chanDuty   <= '0;
      immMode    <= 1'b0;
      useMaster  <= 1'b0;
    end else if (wrEn) begin
      case (addrDec)
        ADDR_PERIOD: periodVal  <= wrData;
        ADDR_MASTER: masterDuty <= wrData;
        ADDR_CHAN:   chanDuty   <= wrData;
        ADDR_CFG: begin
          immMode   <= wrData[0];
          useMaster <= wrData[1];
        end
        default: ;
      endcase
    end
  end

  assign rawDuty = useMaster ? masterDuty : chanDuty;

  always_comb begin
    strb.useDirect = immMode;
    strb.loadDuty  = immMode | atWrap;
  end

  // R9
  unsel_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && ((wrAddr == 2'd2 && useMaster) || (wrAddr == 2'd1 && !useMaster)))
      |=> $stable(rawDuty));

endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_duty_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int MIN_DUTY = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dutyStrobe_t      strb,
  input  logic [CNT_W-1:0] periodVal,
  input  logic [CNT_W-1:0] rawDuty,
  output logic             atWrap,
  output logic             pwmHigh,
  output logic             pwmLow
);

  localparam logic [CNT_W-1:0] MinDuty = CNT_W'(MIN_DUTY);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   cntNext;
  logic [CNT_W-1:0] dutyClamped;
  logic [CNT_W-1:0] dutyAct;
  logic [CNT_W-1:0] dutyEff;

  assign cntNext     = {1'b0, cnt} + 1'b1;
  assign atWrap      = cntNext >= {1'b0, periodVal};
  assign dutyClamped = (rawDuty < MinDuty) ? '0 : rawDuty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      dutyAct <= '0;
    end else begin
      cnt <= atWrap ? '0 : cntNext[CNT_W-1:0];
      if (strb.loadDuty) dutyAct <= dutyClamped;
    end
  end

  assign dutyEff = strb.useDirect ? dutyClamped : dutyAct;
  assign pwmHigh = cnt < dutyEff;
  assign pwmLow  = ~pwmHigh;

  // R3
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (periodVal != '0 && {1'b0, cnt} + 1'b1 >= {1'b0, periodVal}) |=> (cnt == '0));

  // R7
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadDuty |=> $stable(dutyAct));

endmodule

// File: rtl/pwm_duty_gen.sv
module pwm_duty_gen
  import pwm_duty_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int MIN_DUTY   = 16,
  parameter int RST_PERIOD = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  output logic             pwmHigh,
  output logic             pwmLow
);

  dutyStrobe_t      strb;
  logic [CNT_W-1:0] periodVal;
  logic [CNT_W-1:0] rawDuty;
  logic             immMode;
  logic             atWrap;

  pwm_ctrl #(.CNT_W(CNT_W), .RST_PERIOD(RST_PERIOD)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .atWrap(atWrap), .periodVal(periodVal), .rawDuty(rawDuty),
    .immMode(immMode), .strb(strb)
  );

  pwm_datapath #(.CNT_W(CNT_W), .MIN_DUTY(MIN_DUTY)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .periodVal(periodVal),
    .rawDuty(rawDuty), .atWrap(atWrap), .pwmHigh(pwmHigh), .pwmLow(pwmLow)
  );

  // R4
  small_duty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (immMode && rawDuty < CNT_W'(MIN_DUTY)) |-> !pwmHigh);

  // R6
  full_duty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (immMode && rawDuty >= CNT_W'(MIN_DUTY) && rawDuty >= periodVal) |-> pwmHigh);

endmodule

// File: tb/pwm_duty_gen_tb_top.sv
`timescale 1ns/1ps
module pwm_duty_gen_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        pwmHigh, pwmLow;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm_duty_gen dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pwmHigh(pwmHigh), .pwmLow(pwmLow)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // count highs over n cycles, also checking complement (R2)
  task automatic measure(input int n, output int highs);
    int badCompl = 0;
    highs = 0;
    for (int i = 0; i < n; i++) begin
      if (pwmHigh) highs++;
      if (pwmLow == pwmHigh) badCompl++;
      @(negedge clk);
    end
    check("R2 complement", badCompl, 0);
  endtask

  task automatic waitRise();
    logic prev = pwmHigh;
    forever begin
      @(negedge clk);
      if (!prev && pwmHigh) break;
      prev = pwmHigh;
    end
  endtask

  task automatic countRun(output int n);
    n = 0;
    while (pwmHigh) begin n++; @(negedge clk); end
  endtask

  task automatic testReset();
    check("R1 reset high", int'(pwmHigh), 0);
    check("R1 reset low", int'(pwmLow), 1);
  endtask

  task automatic testBasicDuty();
    int h;
    regWrite(2'd0, 16'd64);
    regWrite(2'd3, 16'h0000);
    regWrite(2'd2, 16'd20);
    settle(140);
    measure(64, h); check("R3 duty 20 of 64", h, 20);
    regWrite(2'd0, 16'd40);
    regWrite(2'd2, 16'd33);
    settle(100);
    measure(40, h); check("R3 duty 33 of 40", h, 33);
    regWrite(2'd0, 16'd64);
  endtask

  task automatic testClamp();
    int h;
    regWrite(2'd2, 16'h000F);
    settle(140);
    measure(128, h); check("R4 buffered 0x000F acts as zero", h, 0);
    regWrite(2'd2, 16'h0010);
    settle(140);
    measure(64, h); check("R5 duty 0x0010 honoured", h, 16);
    regWrite(2'd3, 16'h0001);
    regWrite(2'd2, 16'h0005);
    measure(128, h); check("R4 immediate 0x0005 acts as zero", h, 0);
    regWrite(2'd2, 16'h0001);
    measure(64, h); check("R4 immediate 0x0001 acts as zero", h, 0);
    regWrite(2'd3, 16'h0000);
  endtask

  task automatic testFull();
    int h;
    regWrite(2'd2, 16'd64);
    settle(140);
    measure(128, h); check("R6 duty equal to period", h, 128);
    regWrite(2'd2, 16'd300);
    settle(140);
    measure(128, h); check("R6 duty above period", h, 128);
  endtask

  task automatic testBuffered();
    int n;
    regWrite(2'd3, 16'h0000);
    regWrite(2'd2, 16'd20);
    settle(140);
    waitRise();               // counter at 0
    regWrite(2'd2, 16'd40);   // counter now 1
    countRun(n); check("R7 current pulse unchanged", n, 19);
    waitRise();
    countRun(n); check("R7 new duty next period", n, 40);
  endtask

  task automatic testImmediate();
    int n;
    regWrite(2'd3, 16'h0000);
    regWrite(2'd2, 16'd20);
    settle(140);
    regWrite(2'd3, 16'h0001);
    waitRise();
    regWrite(2'd2, 16'd40);
    countRun(n); check("R8 immediate widens current pulse", n, 39);
    waitRise();
    regWrite(2'd2, 16'h0008);
    check("R8 R4 immediate small value low at once", int'(pwmHigh), 0);
    check("R8 R4 low side high at once", int'(pwmLow), 1);
    regWrite(2'd3, 16'h0000);
  endtask

  task automatic testSource();
    int h;
    regWrite(2'd1, 16'd30);
    regWrite(2'd2, 16'd50);
    regWrite(2'd3, 16'h0002);
    settle(140);
    measure(64, h); check("R9 master source", h, 30);
    regWrite(2'd2, 16'd10);
    settle(140);
    measure(64, h); check("R9 unselected channel write ignored", h, 30);
    regWrite(2'd2, 16'd50);
    regWrite(2'd3, 16'h0000);
    settle(140);
    measure(64, h); check("R9 channel source", h, 50);
    regWrite(2'd1, 16'd25);
    settle(140);
    measure(64, h); check("R9 unselected master write ignored", h, 50);
  endtask

  initial begin
    settle(3);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasicDuty();
    testClamp();
    testFull();
    testBuffered();
    testImmediate();
    testSource();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule